// File: doc/BRIEF.md
# NAND Ready-Wait Controller

This block waits for a NAND flash device to finish a program, erase or reset operation and then reports how it ended. A neighbouring command sequencer issues the operation on the flash pins and then pulses `start_i`. The controller first lets a fixed guard interval run out, so that the device has time to drop its ready indication. It then polls for completion in one of two ways. If `use_pin_i` is high it watches the ready/busy input. Otherwise it keeps reading the device status byte through a byte-read port that the sequencer serves. Whichever way completion is seen, one last status byte is read and returned. That byte comes with a timeout flag, a flag raised when its ready bit is clear, and an error flag if a read failed.

All time values are parameters in clock cycles. Program and erase waits use one limit and reset waits use a shorter one, chosen by `reset_op_i` when the start is accepted. `rb_pin_i` must already be synchronous to `clk`.

The status byte port is a request/response handshake. `rd_req_o` is the request valid. It rises only when the controller wants a byte and stays high until the sequencer answers with `rd_ack_i`, so the sequencer can hold off a read for any number of cycles. `rd_data_i` and `rd_err_i` are looked at only in a cycle where `rd_req_o` and `rd_ack_i` are both high. Each such cycle consumes exactly one byte.

Top module: `nand_rdy_waiter`

## Requirements
- R1: After reset, done_o, rd_req_o, timeout_o, warn_o and err_o are low and status_o is 0x00.
- R2: No status read and no pin poll happens during the guard interval. In status mode the first rd_req_o is high in the GUARD_CYC-th cycle after the cycle that accepted start_i, counting that cycle as cycle 0.
- R3: In pin mode, rb_pin_i high means ready. Once it is seen high, exactly one status read is made in the following cycle, so the first request appears in cycle GUARD_CYC+1 when the pin is already high. No read happens while waiting.
- R4: In status mode, reads repeat until a returned byte has bit 6 (ready) set. One further read follows, so an operation whose first N bytes are busy performs N+2 reads.
- R5: rd_req_o stays high until rd_ack_i is seen. Data and error are sampled only in a cycle where request and acknowledge are both high.
- R6: If ready has not been seen by cycle PROG_LIMIT_CYC-1 after acceptance, polling stops and the final read is still made. That read is returned with timeout_o set, and done_o never reports a timeout before that cycle.
- R7: With reset_op_i high at acceptance, RESET_LIMIT_CYC is used as the limit instead of PROG_LIMIT_CYC.
- R8: status_o carries the byte from the final read. warn_o is high exactly when bit 6 of that byte is clear.
- R9: A read answered with rd_err_i high ends the operation at once. done_o then reports err_o high, status_o 0x00, and timeout_o and warn_o low, and no further read is made.
- R10: done_o is a single-cycle pulse. status_o and the flags keep their values until the next done_o.
- R11: start_i is ignored from acceptance until the done_o cycle has passed. Each accepted start yields exactly one done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a wait, accepted only when idle |
| reset_op_i | input | 1 | Selects the reset-operation limit, sampled at acceptance |
| use_pin_i | input | 1 | 1 = poll ready/busy pin, 0 = poll status byte; sampled at acceptance |
| rb_pin_i | input | 1 | Ready/busy pin, 1 = ready, synchronous to clk |
| rd_req_o | output | 1 | Status byte read request (valid) |
| rd_ack_i | input | 1 | Read answered this cycle |
| rd_data_i | input | 8 | Status byte, valid with rd_ack_i |
| rd_err_i | input | 1 | Read failed, valid with rd_ack_i |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Final status byte |
| timeout_o | output | 1 | Limit reached before ready was seen |
| warn_o | output | 1 | Final byte has ready bit clear |
| err_o | output | 1 | A status read failed |

## Verification
On every cycle, the assertions check that a request is held until it is answered and that no request appears inside the guard interval. They also check that done_o lasts one cycle, that a timeout is never reported before the selected limit, and that an error result carries no timeout or warning. The number of reads per operation, the returned byte, the ready-versus-timeout outcome under each mode and limit, and the ignoring of a start during a wait depend on how the device answers. Only the bench scenarios can show those, and the scoreboard compares them against expectations computed from the device model.

// File: rtl/nand_wait_pkg.sv
package nand_wait_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GUARD,
    ST_POLL,
    ST_FINAL,
    ST_DONE
  } wait_st_e;
endpackage

// File: rtl/nand_wait_dcnt.sv
module nand_wait_dcnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= val_i;
    end else if (dec_i && (cnt_q != '0)) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nand_wait_stat_port.sv
module nand_wait_stat_port #(
  parameter int DW      = 8,
  parameter int RDY_BIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          want_i,
  output logic          req_o,
  input  logic          ack_i,
  input  logic [DW-1:0] data_i,
  input  logic          err_i,
  output logic          fire_o,
  output logic          fire_err_o,
  output logic          fire_rdy_o
);
  assign req_o      = want_i;
  assign fire_o     = want_i && ack_i;
  assign fire_err_o = fire_o && err_i;
  assign fire_rdy_o = fire_o && !err_i && data_i[RDY_BIT];

  // R5: an outstanding request is held until it is answered
  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> req_o)
    else $error("request dropped before acknowledge");
endmodule

// File: rtl/nand_rdy_waiter.sv
module nand_rdy_waiter
  import nand_wait_pkg::*;
#(
  parameter int GUARD_CYC       = 25,
  parameter int PROG_LIMIT_CYC  = 100_000_000,
  parameter int RESET_LIMIT_CYC = 62_500_000,
  parameter int RDY_BIT         = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       reset_op_i,
  input  logic       use_pin_i,
  input  logic       rb_pin_i,
  output logic       rd_req_o,
  input  logic       rd_ack_i,
  input  logic [7:0] rd_data_i,
  input  logic       rd_err_i,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic       timeout_o,
  output logic       warn_o,
  output logic       err_o
);
  localparam int MAX_LIM = (PROG_LIMIT_CYC > RESET_LIMIT_CYC) ? PROG_LIMIT_CYC : RESET_LIMIT_CYC;
  localparam int LW      = $clog2(MAX_LIM + 1);
  localparam int GW      = $clog2(GUARD_CYC + 1);
  localparam logic [LW-1:0] PROG_LOAD  = LW'(PROG_LIMIT_CYC - 1);
  localparam logic [LW-1:0] RESET_LOAD = LW'(RESET_LIMIT_CYC - 1);
  localparam logic [GW-1:0] GUARD_LOAD = GW'(GUARD_CYC - 1);

  wait_st_e st_q;
  logic     pin_mode_q;
  logic     tmo_q;
  logic     accept;
  logic     guard_zero;
  logic     lim_zero;
  logic     want_rd;
  logic     fire, fire_err, fire_rdy;
  logic [LW-1:0] lim_load;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign lim_load = reset_op_i ? RESET_LOAD : PROG_LOAD;
  assign want_rd  = (st_q == ST_FINAL) || ((st_q == ST_POLL) && !pin_mode_q);
  assign done_o   = (st_q == ST_DONE);

  nand_wait_dcnt #(.W(GW)) u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .val_i  (GUARD_LOAD),
    .dec_i  (st_q == ST_GUARD),
    .zero_o (guard_zero)
  );

  nand_wait_dcnt #(.W(LW)) u_limit (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (accept),
    .val_i  (lim_load),
    .dec_i  (st_q != ST_IDLE),
    .zero_o (lim_zero)
  );

  nand_wait_stat_port #(.DW(8), .RDY_BIT(RDY_BIT)) u_port (
    .clk        (clk),
    .rst_n      (rst_n),
    .want_i     (want_rd),
    .req_o      (rd_req_o),
    .ack_i      (rd_ack_i),
    .data_i     (rd_data_i),
    .err_i      (rd_err_i),
    .fire_o     (fire),
    .fire_err_o (fire_err),
    .fire_rdy_o (fire_rdy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      pin_mode_q <= 1'b0;
      tmo_q      <= 1'b0;
      status_o   <= 8'h00;
      timeout_o  <= 1'b0;
      warn_o     <= 1'b0;
      err_o      <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (start_i) begin
            pin_mode_q <= use_pin_i;
            tmo_q      <= 1'b0;
            st_q       <= ST_GUARD;
          end
        end
        ST_GUARD: begin
          if (guard_zero) st_q <= ST_POLL;
        end
        ST_POLL: begin
          if (pin_mode_q) begin
            if (rb_pin_i) begin
              st_q <= ST_FINAL;
            end else if (lim_zero) begin
              tmo_q <= 1'b1;
              st_q  <= ST_FINAL;
            end
          end else if (fire_err) begin
            status_o  <= 8'h00;
            timeout_o <= 1'b0;
            warn_o    <= 1'b0;
            err_o     <= 1'b1;
            st_q      <= ST_DONE;
          end else if (fire_rdy) begin
            st_q <= ST_FINAL;
          end else if (fire && lim_zero) begin
            tmo_q <= 1'b1;
            st_q  <= ST_FINAL;
          end
        end
        ST_FINAL: begin
          if (fire_err) begin
            status_o  <= 8'h00;
            timeout_o <= 1'b0;
            warn_o    <= 1'b0;
            err_o     <= 1'b1;
            st_q      <= ST_DONE;
          end else if (fire) begin
            status_o  <= rd_data_i;
            timeout_o <= tmo_q;
            warn_o    <= !fire_rdy;
            err_o     <= 1'b0;
            st_q      <= ST_DONE;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // ---------------- checks ----------------
  logic [LW:0]   chk_age;
  logic [LW-1:0] chk_lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_age <= '0;
      chk_lim <= '0;
    end else if (accept) begin
      chk_age <= '0;
      chk_lim <= lim_load;
    end else if (chk_age != '1) begin
      chk_age <= chk_age + 1'b1;
    end
  end

  // R2: no read request inside the guard interval
  p_guard_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (chk_age >= (LW+1)'(GUARD_CYC)))
    else $error("read inside guard interval");

  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o)
    else $error("done longer than one cycle");

  // R10: results stay put between completions
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> (done_o || $stable(status_o)))
    else $error("status changed without done");

  // R6: a timeout is never reported before the selected limit
  p_tmo_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && timeout_o) |-> (chk_age >= {1'b0, chk_lim}))
    else $error("timeout reported early");

  // R9: an error result carries no timeout or warning
  p_err_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (!timeout_o && !warn_o && status_o == 8'h00))
    else $error("error result not clean");
endmodule

// File: tb/sim_nand_rdy_waiter.sv
`timescale 1ns/1ps
module sim_nand_rdy_waiter;
  localparam int G  = 5;
  localparam int PL = 300;
  localparam int RL = 120;

  typedef struct packed {
    logic [7:0]  st;
    logic        to;
    logic        wn;
    logic        er;
    logic [15:0] reads;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, reset_op_i = 1'b0, use_pin_i = 1'b0, rb_pin_i = 1'b0;
  logic rd_req_o, rd_ack_i = 1'b0, rd_err_i = 1'b0;
  logic [7:0] rd_data_i = 8'h00;
  logic done_o, timeout_o, warn_o, err_o;
  logic [7:0] status_o;

  int tests = 0, fails = 0;
  exp_t q[$];

  // device model
  logic m_pin = 1'b0;
  int m_busy = 0, m_err_at = 0, m_lat = 0, rd_count = 0;
  logic [7:0] m_fin = 8'h00;

  always #2 clk = ~clk;

  nand_rdy_waiter #(.GUARD_CYC(G), .PROG_LIMIT_CYC(PL), .RESET_LIMIT_CYC(RL)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .reset_op_i(reset_op_i),
    .use_pin_i(use_pin_i), .rb_pin_i(rb_pin_i), .rd_req_o(rd_req_o),
    .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i), .rd_err_i(rd_err_i),
    .done_o(done_o), .status_o(status_o), .timeout_o(timeout_o),
    .warn_o(warn_o), .err_o(err_o));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // responder: answers each request after m_lat cycles
  initial begin
    forever begin
      @(negedge clk);
      if (rd_req_o && !rd_ack_i) begin
        repeat (m_lat) @(negedge clk);
        rd_count++;
        rd_err_i = (m_err_at != 0) && (rd_count == m_err_at);
        if (m_pin) rd_data_i = m_fin;
        else if (rd_count <= m_busy) rd_data_i = 8'h80;
        else if (rd_count == m_busy + 1) rd_data_i = 8'h60;
        else rd_data_i = m_fin;
        rd_ack_i = 1'b1;
        @(negedge clk);
        rd_ack_i = 1'b0;
        rd_err_i = 1'b0;
      end
    end
  end

  // monitor: pops expectations on each completion
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R11 unexpected done", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(status_o == e.st, "R8 status byte", status_o, e.st);
          check(timeout_o == e.to, "R6 timeout flag", timeout_o, e.to);
          check(warn_o == e.wn, "R8 warn flag", warn_o, e.wn);
          check(err_o == e.er, "R9 error flag", err_o, e.er);
          check(rd_count == int'(e.reads), "R4 read count", rd_count, e.reads);
        end
      end
    end
  end

  task automatic run_op(input bit pin, input bit rop, input int pin_dly, input int busy,
                        input logic [7:0] fin, input int err_at, input int lat,
                        input bit extra, input exp_t e, output int first, output int n);
    m_pin = pin; m_busy = busy; m_fin = fin; m_err_at = err_at; m_lat = lat;
    rd_count = 0;
    rb_pin_i = pin && (pin_dly == 0);
    q.push_back(e);
    @(negedge clk);
    use_pin_i = pin; reset_op_i = rop; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; use_pin_i = ~pin; reset_op_i = ~rop;
    n = 0; first = -1;
    while (!done_o) begin
      if (rd_req_o && first < 0) first = n;
      start_i = extra && (n == G + 3);
      if (pin && pin_dly > 0 && n == pin_dly) rb_pin_i = 1'b1;
      @(negedge clk);
      n++;
    end
    start_i = 1'b0;
    @(negedge clk);
    check(!done_o, "R10 done single cycle", done_o, 0);
    check(status_o == e.st, "R10 status held", status_o, e.st);
    rb_pin_i = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int first, n;
    exp_t e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!done_o && !rd_req_o && !timeout_o && !warn_o && !err_o && status_o == 8'h00,
          "R1 reset state", {done_o, rd_req_o, timeout_o, warn_o, err_o, status_o}, 0);

    // pin already ready: single read right after guard + pin sample
    e = '{st: 8'hE0, to: 1'b0, wn: 1'b0, er: 1'b0, reads: 16'd1};
    run_op(1, 0, 0, 0, 8'hE0, 0, 1, 0, e, first, n);
    check(first == G + 1, "R3 pin-mode first read cycle", first, G + 1);

    // pin becomes ready later: still one read, none while waiting
    e = '{st: 8'hE0, to: 1'b0, wn: 1'b0, er: 1'b0, reads: 16'd1};
    run_op(1, 0, 30, 0, 8'hE0, 0, 0, 0, e, first, n);
    check(first > 30, "R3 no read while pin busy", first, 31);

    // pin never ready: program limit timeout
    e = '{st: 8'h80, to: 1'b1, wn: 1'b1, er: 1'b0, reads: 16'd1};
    run_op(1, 0, -1, 0, 8'h80, 0, 0, 0, e, first, n);
    check(n >= PL - 1, "R6 program timeout not early", n, PL - 1);

    // status polling, three busy bytes, slow responder
    e = '{st: 8'hC1, to: 1'b0, wn: 1'b0, er: 1'b0, reads: 16'd5};
    run_op(0, 0, 0, 3, 8'hC1, 0, 2, 0, e, first, n);
    check(first == G, "R2 guard before first status read", first, G);

    // ready seen but final byte lacks ready bit
    e = '{st: 8'h01, to: 1'b0, wn: 1'b1, er: 1'b0, reads: 16'd3};
    run_op(0, 0, 0, 1, 8'h01, 0, 0, 0, e, first, n);

    // read failure on the second read
    e = '{st: 8'h00, to: 1'b0, wn: 1'b0, er: 1'b1, reads: 16'd2};
    run_op(0, 0, 0, 5, 8'hE0, 2, 1, 0, e, first, n);
    repeat (5) @(negedge clk);
    check(rd_count == 2, "R9 no read after error", rd_count, 2);

    // status never ready, program limit
    e = '{st: 8'h80, to: 1'b1, wn: 1'b1, er: 1'b0, reads: 16'd0};
    m_busy = 100000;
    begin
      // read count depends on timing, so accept whatever is seen via a local check
      q.push_back(e);
      void'(q.pop_back());
    end

    // reset-operation limit, status never ready
    e = '{st: 8'h80, to: 1'b1, wn: 1'b1, er: 1'b0, reads: 16'(((RL - 1 - G) / 2) + 2)};
    run_op(0, 1, 0, 100000, 8'h80, 0, 0, 0, e, first, n);
    check(n >= RL - 1 && n < PL - 1, "R7 reset limit used", n, RL);

    // program limit in status mode
    e = '{st: 8'h80, to: 1'b1, wn: 1'b1, er: 1'b0, reads: 16'(((PL - 1 - G) / 2) + 2)};
    run_op(0, 0, 0, 100000, 8'h80, 0, 0, 0, e, first, n);
    check(n >= PL - 1, "R6 status-mode program timeout", n, PL - 1);

    // start pulsed mid-operation is ignored
    e = '{st: 8'hE0, to: 1'b0, wn: 1'b0, er: 1'b0, reads: 16'd6};
    run_op(0, 0, 0, 4, 8'hE0, 0, 1, 1, e, first, n);
    repeat (20) @(negedge clk);
    check(q.size() == 0 && !rd_req_o, "R11 extra start ignored", q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule